// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block draws into a 16-bit-per-pixel frame store held in word-addressed memory, one pixel per memory word. It is driven by a queue of 32-bit commands. Each command either loads one drawing parameter or starts an operation. The parameters are the destination start, the source start, the width, the height and the fill colour. The two operations are a solid rectangle fill and a rectangle copy.

While an operation runs, the engine walks the rectangle row by row. Each new row starts one line pitch further on. The pitch is supplied on a configuration input, in pixels. The engine holds off the command queue until the operation is over, then gives a one-cycle completion pulse.

A fill writes one pixel per clock. A copy spends two clocks on each pixel: a read at the source, then a write at the destination.

Top module: `rect_blit_engine`

## Requirements
- R1: After reset, busy, done, mem_we and mem_re are low and cmd_ready is high.
- R2: The opcode sits in cmd_data[31:24]. The setters are:
  - 0x0C loads the destination address and 0x0D loads the source address. Both take bits 23:1 of the command as the word address, which is the byte address divided by two, so bit 0 is dropped.
  - 0x0E loads the width and 0x0F loads the height, each from bits 9:0 only.
  - 0x0B loads the colour from bits 15:0.
- R3: Opcode 0x23 starts a fill. In the clock after the command is accepted, the engine begins writing the colour to every pixel of the rectangle. It writes one pixel per clock, left to right within a row and rows top to bottom.
- R4: Opcode 0x21 starts a copy. For each pixel in raster order, the engine asserts mem_re at the source word for one clock. In the next clock it asserts mem_we at the matching destination word, writing the data the memory returned.
- R5: Row r of a rectangle starts at the base word address plus r times pitch_px. Pixel x of that row lies at that row start plus x.
- R6: busy rises in the clock after a launch is accepted and stays high until the last access is done. While busy is high, cmd_ready is low and no command takes effect.
- R7: done is high for exactly one clock, the clock after the last write. In that clock busy is already low.
- R8: Parameters keep their values across operations, so a second launch reuses them.
- R9: Word addresses wrap modulo 2^23, so the pixel after word 0x7FFFFF is word 0.
- R10: Width and height fields hold count minus one, so 0 gives one pixel and 1023 gives 1024 pixels.
- R11: A command whose opcode is neither a setter nor a launch is accepted and has no effect. It causes no memory access and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_data | input | 32 | Opcode in bits 31:24, operand below |
| pitch_px | input | 12 | Line pitch in pixels |
| mem_addr | output | 23 | Word address of the current access |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Pixel to write |
| mem_re | output | 1 | Read strobe; data is expected one clock later |
| mem_rdata | input | 16 | Read data returned one clock after mem_re |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock pulse when an operation ends |

## Verification
A single-pixel fill and a 1024-wide fill pin down the count-minus-one encoding at both ends of the field. Multi-row fills with different pitches separate a correct row stride from one that steps by the width. Copies from a source whose contents are a function of the address confirm three things: each write carries the data from its own read, reads and writes alternate, and the source and destination walks stay in step. A fill that runs across the top of the address space checks the wrap. A setter sent while busy, followed by a fill that must still use the old colour, shows that blocked commands are dropped. Seeded random fills and copies with random sizes, bases and pitches then mix all of these cases.

// File: rtl/blit_pkg.sv
package blit_pkg;
   localparam logic [7:0] OPC_COLOUR  = 8'h0B;
   localparam logic [7:0] OPC_DST     = 8'h0C;
   localparam logic [7:0] OPC_SRC     = 8'h0D;
   localparam logic [7:0] OPC_WIDTH   = 8'h0E;
   localparam logic [7:0] OPC_HEIGHT  = 8'h0F;
   localparam logic [7:0] OPC_COPY_GO = 8'h21;
   localparam logic [7:0] OPC_FILL_GO = 8'h23;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FILL,
      ST_RD,
      ST_WAIT,
      ST_WR
   } blit_state_t;
endpackage

// File: rtl/blit_cmd_regs.sv
module blit_cmd_regs
   import blit_pkg::*;
#(
   parameter int WADDR_W = 23,
   parameter int CNT_W   = 10,
   parameter int PIX_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  logic [31:0]        cmd,
   input  logic               busy,
   output logic [WADDR_W-1:0] dst_base,
   output logic [WADDR_W-1:0] src_base,
   output logic [CNT_W-1:0]   w_m1,
   output logic [CNT_W-1:0]   h_m1,
   output logic [PIX_W-1:0]   colour,
   output logic               go_fill,
   output logic               go_copy
);
   logic [7:0] opc;
   logic       unused_cmd;

   assign opc        = cmd[31:24];
   assign unused_cmd = ^cmd;

   generate
      if (WADDR_W > 23 || WADDR_W < 2) begin : g_bad_addr
         $error("blit_cmd_regs: WADDR_W must be 2..23");
      end
      if (CNT_W > 16 || CNT_W < 1) begin : g_bad_cnt
         $error("blit_cmd_regs: CNT_W must be 1..16");
      end
      if (PIX_W > 16 || PIX_W < 1) begin : g_bad_pix
         $error("blit_cmd_regs: PIX_W must be 1..16");
      end
   endgenerate

   assign go_fill = accept && (opc == OPC_FILL_GO);
   assign go_copy = accept && (opc == OPC_COPY_GO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dst_base <= '0;
         src_base <= '0;
         w_m1     <= '0;
         h_m1     <= '0;
         colour   <= '0;
      end else if (accept) begin
         case (opc)
            OPC_DST:    dst_base <= cmd[WADDR_W:1];
            OPC_SRC:    src_base <= cmd[WADDR_W:1];
            OPC_WIDTH:  w_m1     <= cmd[CNT_W-1:0];
            OPC_HEIGHT: h_m1     <= cmd[CNT_W-1:0];
            OPC_COLOUR: colour   <= cmd[PIX_W-1:0];
            default: ;
         endcase
      end
   end

   // R8
   param_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(colour) && $stable(dst_base) && $stable(src_base)
                && $stable(w_m1) && $stable(h_m1)));
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
   parameter int WADDR_W = 23,
   parameter int CNT_W   = 10,
   parameter int PITCH_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic               load,
   input  logic               step,
   input  logic [WADDR_W-1:0] dst_base,
   input  logic [WADDR_W-1:0] src_base,
   input  logic [CNT_W-1:0]   w_m1,
   input  logic [CNT_W-1:0]   h_m1,
   input  logic [PITCH_W-1:0] pitch,
   output logic [WADDR_W-1:0] dst_addr,
   output logic [WADDR_W-1:0] src_addr,
   output logic               last
);
   localparam int PAD_W = WADDR_W - PITCH_W;
   localparam int XPAD  = WADDR_W - CNT_W;

   logic [CNT_W-1:0]   x_q, y_q;
   logic [WADDR_W-1:0] dst_row, src_row, pitch_ext, x_ext;
   logic               row_end;

   generate
      if (PAD_W < 1 || XPAD < 1) begin : g_bad_w
         $error("blit_walker: address width must exceed pitch and count widths");
      end
   endgenerate

   assign pitch_ext = {{PAD_W{1'b0}}, pitch};
   assign x_ext     = {{XPAD{1'b0}}, x_q};
   assign row_end   = (x_q == w_m1);
   assign last      = row_end && (y_q == h_m1);
   assign dst_addr  = dst_row + x_ext;
   assign src_addr  = src_row + x_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q     <= '0;
         y_q     <= '0;
         dst_row <= '0;
         src_row <= '0;
      end else if (load) begin
         x_q     <= '0;
         y_q     <= '0;
         dst_row <= dst_base;
         src_row <= src_base;
      end else if (step) begin
         if (row_end) begin
            x_q     <= '0;
            y_q     <= y_q + 1'b1;
            dst_row <= dst_row + pitch_ext;
            src_row <= src_row + pitch_ext;
         end else begin
            x_q <= x_q + 1'b1;
         end
      end
   end

   // R10
   walk_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (x_q <= w_m1 && y_q <= h_m1));

   // R5
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && step && row_end && !last) |=> (dst_row == $past(dst_row) + $past(pitch_ext)));
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
   import blit_pkg::*;
#(
   parameter int WADDR_W = 23,
   parameter int CNT_W   = 10,
   parameter int PITCH_W = 12,
   parameter int PIX_W   = 16,
   parameter int RD_LAT  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic [31:0]        cmd_data,
   input  logic [PITCH_W-1:0] pitch_px,
   output logic [WADDR_W-1:0] mem_addr,
   output logic               mem_we,
   output logic [PIX_W-1:0]   mem_wdata,
   output logic               mem_re,
   input  logic [PIX_W-1:0]   mem_rdata,
   output logic               busy,
   output logic               done
);
   localparam int LAT_W = $clog2(RD_LAT + 1);

   blit_state_t        state_q, after_rd;
   logic               accept, go_fill, go_copy, step, last;
   logic [WADDR_W-1:0] dst_base, src_base, dst_addr, src_addr;
   logic [CNT_W-1:0]   w_m1, h_m1;
   logic [PIX_W-1:0]   colour;
   logic [LAT_W-1:0]   lat_q, lat_init;
   logic               done_q;

   generate
      if (RD_LAT < 1 || RD_LAT > 8) begin : g_bad_lat
         $error("rect_blit_engine: RD_LAT must be 1..8");
      end
      if (RD_LAT == 1) begin : g_direct
         assign after_rd = ST_WR;
         assign lat_init = '0;
      end else begin : g_delayed
         assign after_rd = ST_WAIT;
         assign lat_init = LAT_W'(RD_LAT - 2);
      end
   endgenerate

   assign busy      = (state_q != ST_IDLE);
   assign cmd_ready = !busy;
   assign accept    = cmd_valid && cmd_ready;
   assign step      = (state_q == ST_FILL) || (state_q == ST_WR);
   assign done      = done_q;

   blit_cmd_regs #(
      .WADDR_W (WADDR_W),
      .CNT_W   (CNT_W),
      .PIX_W   (PIX_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .cmd      (cmd_data),
      .busy     (busy),
      .dst_base (dst_base),
      .src_base (src_base),
      .w_m1     (w_m1),
      .h_m1     (h_m1),
      .colour   (colour),
      .go_fill  (go_fill),
      .go_copy  (go_copy)
   );

   blit_walker #(
      .WADDR_W (WADDR_W),
      .CNT_W   (CNT_W),
      .PITCH_W (PITCH_W)
   ) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (busy),
      .load     (go_fill || go_copy),
      .step     (step),
      .dst_base (dst_base),
      .src_base (src_base),
      .w_m1     (w_m1),
      .h_m1     (h_m1),
      .pitch    (pitch_px),
      .dst_addr (dst_addr),
      .src_addr (src_addr),
      .last     (last)
   );

   always_comb begin
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      mem_addr  = dst_addr;
      mem_wdata = colour;
      case (state_q)
         ST_FILL: mem_we = 1'b1;
         ST_RD: begin
            mem_re   = 1'b1;
            mem_addr = src_addr;
         end
         ST_WAIT: mem_addr = src_addr;
         ST_WR: begin
            mem_we    = 1'b1;
            mem_wdata = mem_rdata;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lat_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (go_fill)      state_q <= ST_FILL;
               else if (go_copy) state_q <= ST_RD;
            end
            ST_FILL: begin
               if (last) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            ST_RD: begin
               state_q <= after_rd;
               lat_q   <= lat_init;
            end
            ST_WAIT: begin
               if (lat_q == '0) state_q <= ST_WR;
               else             lat_q   <= lat_q - 1'b1;
            end
            ST_WR: begin
               if (last) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  state_q <= ST_RD;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R6
   launch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(mem_we || mem_re));

   // R4
   one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));
endmodule

// File: tb/sim_rect_blit_engine.sv
module sim_rect_blit_engine;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 23;
   localparam logic [AW-1:0] AMASK = '1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [31:0] cmd_data = '0;
   logic [11:0] pitch_px = 12'd16;
   logic [AW-1:0] mem_addr;
   logic        mem_we, mem_re, busy, done;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;
   string cur_req = "R3";

   logic [AW-1:0] exp_wa[$];
   logic [15:0]   exp_wd[$];
   logic [AW-1:0] exp_ra[$];

   logic [AW-1:0] s_dst = '0, s_src = '0;
   int            s_w = 1, s_h = 1;
   logic [15:0]   s_col = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rect_blit_engine u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_data  (cmd_data),
      .pitch_px  (pitch_px),
      .mem_addr  (mem_addr),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .mem_re    (mem_re),
      .mem_rdata (mem_rdata),
      .busy      (busy),
      .done      (done)
   );

   function automatic logic [15:0] pat(input logic [AW-1:0] a);
      return a[15:0] ^ 16'hA5C3 ^ {a[22:16], 9'h0};
   endfunction

   always @(posedge clk) if (mem_re) mem_rdata <= pat(mem_addr);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (mem_we) begin
            if (exp_wa.size() == 0) chk(0, cur_req, "unexpected write", {9'h0, mem_addr}, 0);
            else begin
               chk(mem_addr == exp_wa[0], cur_req, "write addr", {9'h0, mem_addr}, {9'h0, exp_wa[0]});
               chk(mem_wdata == exp_wd[0], cur_req, "write data", {16'h0, mem_wdata}, {16'h0, exp_wd[0]});
               void'(exp_wa.pop_front());
               void'(exp_wd.pop_front());
            end
         end
         if (mem_re) begin
            if (exp_ra.size() == 0) chk(0, cur_req, "unexpected read", {9'h0, mem_addr}, 0);
            else begin
               chk(mem_addr == exp_ra[0], cur_req, "read addr", {9'h0, mem_addr}, {9'h0, exp_ra[0]});
               void'(exp_ra.pop_front());
            end
         end
      end
   end

   task automatic send(input logic [31:0] c);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data  = c;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // bench model of the R2 setter encoding
   task automatic setp(input logic [7:0] op, input logic [23:0] v);
      send({op, v});
      case (op)
         8'h0C: s_dst = v[23:1];
         8'h0D: s_src = v[23:1];
         8'h0E: s_w = int'(v[9:0]) + 1;
         8'h0F: s_h = int'(v[9:0]) + 1;
         8'h0B: s_col = v[15:0];
         default: ;
      endcase
   endtask

   task automatic build_exp(input bit is_copy);
      for (int y = 0; y < s_h; y++)
         for (int x = 0; x < s_w; x++) begin
            logic [AW-1:0] d, s;
            d = (s_dst + AW'(y) * AW'(pitch_px) + AW'(x)) & AMASK;
            s = (s_src + AW'(y) * AW'(pitch_px) + AW'(x)) & AMASK;
            exp_wa.push_back(d);
            if (is_copy) begin
               exp_ra.push_back(s);
               exp_wd.push_back(pat(s));
            end else exp_wd.push_back(s_col);
         end
   endtask

   task automatic launch(input bit is_copy, input bit poke, input string req);
      int n, cyc, want;
      cur_req = req;
      n = s_w * s_h;
      want = is_copy ? 2 * n + 1 : n + 1;
      build_exp(is_copy);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data  = is_copy ? 32'h2100_0000 : 32'h2300_0000;
      @(negedge clk);
      cmd_valid = 1'b0;
      cyc = 1;
      // R6: busy rises in the clock after acceptance
      chk(busy == 1'b1, "R6", "busy after launch", {31'h0, busy}, 1);
      while (!done && cyc < 5000) begin
         if (poke && cyc == 2) begin
            cmd_valid = 1'b1;
            cmd_data  = 32'h0B00_BEEF;
         end
         @(negedge clk);
         if (poke && cyc == 2) begin
            // R6: setter offered while busy is refused
            chk(cmd_ready == 1'b0, "R6", "ready while busy", {31'h0, cmd_ready}, 0);
            cmd_valid = 1'b0;
         end
         cyc++;
      end
      chk(cyc == want, req, "cycles to done", cyc, want);
      // R7
      chk(busy == 1'b0, "R7", "busy with done", {31'h0, busy}, 0);
      @(negedge clk);
      chk(done == 1'b0, "R7", "done one clock", {31'h0, done}, 0);
      chk(exp_wa.size() == 0 && exp_ra.size() == 0, req, "accesses left over",
          exp_wa.size() + exp_ra.size(), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL R6 watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(!busy && !done && !mem_we && !mem_re && cmd_ready, "R1", "reset outputs",
          {27'h0, busy, done, mem_we, mem_re, cmd_ready}, 1);

      // R10: one-pixel fill
      pitch_px = 12'd20;
      setp(8'h0B, 24'h00_1357);
      setp(8'h0C, 24'h00_0100);
      setp(8'h0E, 24'h00_0000);
      setp(8'h0F, 24'h00_0000);
      launch(0, 0, "R10");

      // R2: bit0 of address dropped, width bits above 9 ignored
      setp(8'h0C, 24'h00_0203);
      setp(8'h0E, 24'h00_FC03);
      setp(8'h0F, 24'h00_0002);
      chk(s_dst == 23'h101 && s_w == 4, "R2", "bench decode", {9'h0, s_dst}, 32'h101);
      launch(0, 0, "R2");

      // R5: different pitch
      pitch_px = 12'd7;
      setp(8'h0B, 24'h00_F00D);
      launch(0, 0, "R5");

      // R4: copy 3x2
      pitch_px = 12'd32;
      setp(8'h0D, 24'h00_4000);
      setp(8'h0C, 24'h00_8000);
      setp(8'h0E, 24'h00_0002);
      setp(8'h0F, 24'h00_0001);
      launch(1, 0, "R4");

      // R9: wrap at the top of the word space
      setp(8'h0C, 24'hFF_FFFE);
      setp(8'h0F, 24'h00_0000);
      launch(0, 0, "R9");

      // R6 and R8: refused setter, then reuse of old colour
      setp(8'h0B, 24'h00_2468);
      setp(8'h0C, 24'h00_0600);
      setp(8'h0E, 24'h00_0005);
      setp(8'h0F, 24'h00_0003);
      launch(0, 1, "R6");
      setp(8'h0E, 24'h00_0000);
      setp(8'h0F, 24'h00_0000);
      launch(0, 0, "R8");

      // R11: unknown opcode
      cur_req = "R11";
      send(32'h2400_FFFF);
      for (int i = 0; i < 3; i++) begin
         chk(!busy && cmd_ready, "R11", "unknown opcode idle", {30'h0, busy, cmd_ready}, 1);
         @(negedge clk);
      end

      // R10: widest row
      setp(8'h0E, 24'h00_03FF);
      setp(8'h0F, 24'h00_0001);
      pitch_px = 12'd1024;
      launch(0, 0, "R10");

      // R3 R4 R5: seeded random mix
      for (int i = 0; i < 24; i++) begin
         pitch_px = 12'(8 + ($urandom % 40));
         setp(8'h0C, 24'($urandom));
         setp(8'h0D, 24'($urandom));
         setp(8'h0E, 24'($urandom % 8));
         setp(8'h0F, 24'($urandom % 6));
         setp(8'h0B, 24'($urandom));
         launch(($urandom % 2) == 1, 0, (i % 2 == 0) ? "R3" : "R5");
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule